// File: doc/BRIEF.md
# Phase Spillover Removal and Averager

This block sits after a time interval counter that compares two 1 PPS (or 10 PPS) pulse trains. Each raw reading is a signed phase value in counter LSBs. A reading jumps by about one divider period when the measured interval crosses the edge of that period. The block recognises each such jump and cancels it with a running offset. The result is a continuous phase record, held in 48 bits, that stays valid over records lasting many days.

After unwrapping, the record is reduced in rate by a programmable factor N from 1 to 100. In averaging mode, each group of N samples is summed and then divided by N in a bit-serial divider. In decimating mode, only the first sample of each group is passed on. Changing the factor or the mode discards the partial group, and the count starts again with the next sample.

The sources deliver one reading per pulse, so readings are far apart. In averaging mode, successive readings are expected to be at least SUM_W+2 clock cycles apart (57 cycles with the default parameters). SUM_W is ACC_W+FACT_W, which is 55 by default.

Top module: `phase_unwrap_reducer`

## Requirements
- R1: For every reading except the first after reset, let d = raw − previous raw. If d > floor(P/2), the offset decreases by P. If d < −floor(P/2), the offset increases by P. Otherwise the offset is unchanged. P is wrap_period. A difference of exactly ±floor(P/2) does not count as a spillover.
- R2: Each unwrapped value is the sign-extended raw reading plus the offset, carried in 48 signed bits. A record that wraps many times past the 32-bit range is reproduced without loss.
- R3: With mode_avg=1, the output is the sum of N consecutive unwrapped samples divided by N, truncated toward zero. It appears on out_valid for one cycle, SUM_W+1 rising edges after the edge that accepts the Nth sample.
- R4: With mode_avg=0, the output is the first unwrapped sample of each group of N. It is valid for one cycle, one edge after the edge that accepts that sample. The other N−1 samples of the group produce no output.
- R5: The factor is accepted from 1 to 100, including 10 and 100. A factor of 0 behaves as a factor of 1.
- R6: Any change of factor or mode_avg drops the partial group and cancels a division still in progress. Counting restarts with the next accepted sample, and the cancelled group produces no output.
- R7: During reset and after it, out_valid is 0 and out_phase is 0. The offset starts at 0, so the first reading after reset is unwrapped to its own value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A raw reading is present this cycle |
| in_phase | input | IN_W (32) | Signed raw phase reading, LSB units |
| wrap_period | input | IN_W (32) | Divider period in LSB units (positive) |
| mode_avg | input | 1 | 1 = block average, 0 = decimate |
| factor | input | FACT_W (7) | Reduction factor N, 1..100 (0 treated as 1) |
| out_valid | output | 1 | One-cycle strobe for a reduced sample |
| out_phase | output | ACC_W (48) | Signed unwrapped, reduced phase |

## Verification
Call k the edge that accepts a reading. A decimated result is due just after edge k+1. An averaged result is due just after edge k+SUM_W+1 (k+56 by default), where k is the edge that accepts the last reading of the group. The driver takes k from a free-running edge counter and stores that due cycle with the expected value it computes. The monitor samples on the falling edge and compares both the value and the arrival cycle. A cancelled division is removed from the expected queue, so any late output it produced would show up as an unexpected strobe.

// File: rtl/phase_unwrap_reducer.sv
module phase_unwrap_reducer #(
  parameter int IN_W   = 32,
  parameter int ACC_W  = 48,
  parameter int FACT_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_phase,
  input  logic        [IN_W-1:0]  wrap_period,
  input  logic                    mode_avg,
  input  logic      [FACT_W-1:0]  factor,
  output logic                    out_valid,
  output logic signed [ACC_W-1:0] out_phase
);
  localparam int SUM_W = ACC_W + FACT_W;
  localparam int CNT_W = $clog2(SUM_W + 1);
  localparam logic [CNT_W-1:0] DSTEPS = CNT_W'(SUM_W);

  logic signed [IN_W-1:0]  prev_q;
  logic                    have_prev;
  logic signed [ACC_W-1:0] offset_q, offset_nxt, per_ext, raw_ext, u_val;
  logic                    u_valid;
  logic signed [IN_W:0]    diff, half;

  assign diff    = $signed({in_phase[IN_W-1], in_phase}) - $signed({prev_q[IN_W-1], prev_q});
  assign half    = $signed({2'b00, wrap_period[IN_W-1:1]});
  assign per_ext = $signed({{(ACC_W-IN_W){1'b0}}, wrap_period});
  assign raw_ext = $signed({{(ACC_W-IN_W){in_phase[IN_W-1]}}, in_phase});

  always_comb begin
    offset_nxt = offset_q;
    if (have_prev) begin
      if (diff > half)       offset_nxt = offset_q - per_ext;
      else if (diff < -half) offset_nxt = offset_q + per_ext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= '0;
      have_prev <= 1'b0;
      offset_q  <= '0;
      u_val     <= '0;
      u_valid   <= 1'b0;
    end else begin
      u_valid <= in_valid;
      if (in_valid) begin
        prev_q    <= in_phase;
        have_prev <= 1'b1;
        offset_q  <= offset_nxt;
        u_val     <= raw_ext + offset_nxt;
      end
    end
  end

  logic [FACT_W-1:0]       eff, cnt;
  logic [FACT_W:0]         cfg_q;
  logic                    chg, last;
  logic signed [SUM_W-1:0] sum, sum_nxt, sum_abs;

  assign eff     = (factor == '0) ? FACT_W'(1) : factor;
  assign chg     = {mode_avg, factor} != cfg_q;
  assign last    = cnt == eff - 1'b1;
  assign sum_nxt = sum + $signed({{(SUM_W-ACC_W){u_val[ACC_W-1]}}, u_val});
  assign sum_abs = sum_nxt[SUM_W-1] ? -sum_nxt : sum_nxt;

  logic                    busy, dneg, ge;
  logic [CNT_W-1:0]        dcnt;
  logic [SUM_W-1:0]        dq, dq_nx;
  logic [FACT_W-1:0]       rem, r_nx, dvs;
  logic [FACT_W:0]         r_sh;
  logic [ACC_W-1:0]        q_lo;

  assign r_sh  = {rem, dq[SUM_W-1]};
  assign ge    = r_sh >= {1'b0, dvs};
  assign r_nx  = ge ? FACT_W'(r_sh - {1'b0, dvs}) : r_sh[FACT_W-1:0];
  assign dq_nx = {dq[SUM_W-2:0], ge};
  assign q_lo  = dq_nx[ACC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      cnt       <= '0;
      sum       <= '0;
      busy      <= 1'b0;
      dneg      <= 1'b0;
      dcnt      <= '0;
      dq        <= '0;
      rem       <= '0;
      dvs       <= '0;
      out_valid <= 1'b0;
      out_phase <= '0;
    end else begin
      out_valid <= 1'b0;
      if (chg) begin
        cfg_q <= {mode_avg, factor};
        cnt   <= '0;
        sum   <= '0;
        busy  <= 1'b0;
      end else begin
        if (busy) begin
          dq   <= dq_nx;
          rem  <= r_nx;
          dcnt <= dcnt - 1'b1;
          if (dcnt == CNT_W'(1)) begin
            busy      <= 1'b0;
            out_valid <= 1'b1;
            out_phase <= dneg ? -$signed(q_lo) : $signed(q_lo);
          end
        end
        if (u_valid) begin
          if (!mode_avg && cnt == '0) begin
            out_valid <= 1'b1;
            out_phase <= u_val;
          end
          if (last) begin
            cnt <= '0;
            sum <= '0;
            if (mode_avg) begin
              busy <= 1'b1;
              dcnt <= DSTEPS;
              dq   <= sum_abs;
              rem  <= '0;
              dneg <= sum_nxt[SUM_W-1];
              dvs  <= eff;
            end
          end else begin
            cnt <= cnt + 1'b1;
            sum <= mode_avg ? sum_nxt : '0;
          end
        end
      end
    end
  end

  // R1
  offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (offset_q == $past(offset_q) ||
                  ($past(have_prev) && (offset_q == $past(offset_q) + $past(per_ext) ||
                                        offset_q == $past(offset_q) - $past(per_ext)))));

  // R3
  div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(chg)) |-> out_valid);

  // R4
  dec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(mode_avg) && !$past(busy)) |-> $past(u_valid));

  // R6
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> (cnt == '0 && !busy && !out_valid));
endmodule

// File: tb/phase_unwrap_reducer_tb.sv
module phase_unwrap_reducer_tb;
  localparam int SUM_W = 55;

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, mode_avg = 1'b0;
  logic signed [31:0] in_phase = '0;
  logic [31:0] wrap_period = 32'd1000;
  logic [6:0]  factor = 7'd1;
  logic out_valid;
  logic signed [47:0] out_phase;

  always #2 clk = ~clk;

  phase_unwrap_reducer u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_phase(in_phase),
    .wrap_period(wrap_period), .mode_avg(mode_avg), .factor(factor),
    .out_valid(out_valid), .out_phase(out_phase));

  typedef struct { longint val; longint due; string tag; } exp_t;
  exp_t q[$];
  int checks = 0, fails = 0;
  longint cyc = 0;
  bit done = 1'b0, reported = 1'b0;

  longint m_prev, m_off, m_sum;
  bit     m_have;
  int     m_cnt;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      longint act;
      act = {{16{out_phase[47]}}, out_phase};
      if (q.size() == 0) begin
        chk(1'b0, "R6 unexpected output", act, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(act == e.val, e.tag, act, e.val);
        chk(cyc == e.due, {e.tag, " timing"}, cyc, e.due);
      end
    end
  end

  task automatic model_clear();
    m_prev = 0; m_off = 0; m_sum = 0; m_have = 1'b0; m_cnt = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7: outputs idle during reset
    chk(out_valid == 1'b0, "R7 reset out_valid", longint'(out_valid), 0);
    chk(out_phase == '0, "R7 reset out_phase", longint'(out_phase), 0);
    model_clear();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic feed(input longint raw, input string tag, input int gap);
    longint k, d, p, u;
    int eff;
    @(negedge clk);
    in_valid = 1'b1;
    in_phase = raw[31:0];
    k = cyc + 1;
    p = longint'(wrap_period);
    d = raw - m_prev;
    if (m_have) begin
      if (d > p / 2)         m_off -= p;
      else if (d < -(p / 2)) m_off += p;
    end
    m_have = 1'b1;
    m_prev = raw;
    u = raw + m_off;
    eff = (factor == 0) ? 1 : int'(factor);
    if (mode_avg) begin
      m_sum += u;
      m_cnt++;
      if (m_cnt == eff) begin
        q.push_back('{m_sum / eff, k + SUM_W + 1, tag});
        m_sum = 0;
        m_cnt = 0;
      end
    end else begin
      if (m_cnt == 0) q.push_back('{u, k + 1, tag});
      m_cnt = (m_cnt + 1 == eff) ? 0 : m_cnt + 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic set_cfg(input bit m, input int f);
    @(negedge clk);
    if (m != mode_avg || f[6:0] != factor) begin
      m_cnt = 0;
      m_sum = 0;
    end
    mode_avg = m;
    factor = f[6:0];
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    report();
  end

  initial begin
    model_clear();
    do_reset();

    // R1 / R7: spillovers at P=1000, pass-through decimate N=1
    wrap_period = 32'd1000;
    set_cfg(1'b0, 1);
    feed(0,   "R7 first sample", 6);
    feed(500, "R1 half step no wrap", 6);
    feed(0,   "R1 minus half no wrap", 6);
    feed(900, "R1 wrap down", 6);
    feed(950, "R1", 6);
    feed(10,  "R1 wrap up", 6);
    feed(60,  "R1", 6);
    feed(990, "R1 wrap down", 6);
    feed(400, "R1 wrap up", 6);

    // R2: large period, record beyond 32 bits
    wrap_period = 32'd1000000000;
    for (int i = 0; i < 40; i++)
      feed((longint'(i) * 300000000) % 1000000000, "R2 wide unwrap", 4);

    // R3: averaging by 10, values going negative
    do_reset();
    wrap_period = 32'd1000;
    set_cfg(1'b1, 10);
    for (int i = 0; i < 30; i++)
      feed(((200 - 37 * i) % 1000 + 1000) % 1000, "R3 average N=10", 70);

    // R5: averaging by 100
    set_cfg(1'b1, 100);
    for (int i = 0; i < 200; i++)
      feed((i * 7) % 1000, "R5 average N=100", 60);

    // R4: decimation by 10
    set_cfg(1'b0, 10);
    for (int i = 0; i < 30; i++)
      feed((i * 53) % 1000, "R4 decimate N=10", 4);

    // R6: flush a partial group
    set_cfg(1'b1, 10);
    for (int i = 0; i < 4; i++) feed(100 + i, "R6", 60);
    set_cfg(1'b1, 5);
    for (int i = 0; i < 5; i++) feed(300 + 11 * i, "R6 after flush", 60);

    // R6: cancel a division in progress
    for (int i = 0; i < 4; i++) feed(500 + i, "R6", 60);
    feed(504, "R6 cancelled", 3);
    set_cfg(1'b1, 6);
    void'(q.pop_back());
    repeat (70) @(negedge clk);
    for (int i = 0; i < 6; i++) feed(700 - 9 * i, "R6 after cancel", 60);

    // R5: factor 0 acts as 1
    set_cfg(1'b0, 0);
    for (int i = 0; i < 5; i++) feed(50 * i, "R5 factor 0", 4);

    repeat (100) @(negedge clk);
    chk(q.size() == 0, "R3 R4 missing outputs", q.size(), 0);
    done = 1'b1;
    report();
  end
endmodule